// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block settles conditional equality branches while the branch is still in the decode stage of a five-stage pipeline. It does not wait for the memory stage. Decode supplies four things: the incremented PC of the branch, its sign-extended word offset, the two already-resolved register operands, and two decode flags, one for "branch if equal" and one for "branch if not equal". The block compares the operands with an XOR of the bits followed by a zero-detect tree, so no subtractor is needed. In the same cycle it adds the offset, scaled by four, to the incremented PC.

Fetch follows the sequential stream by default, so every branch is treated as not taken until decode proves otherwise. When a branch resolves taken, the block does two things on the next clock edge. It loads the fetch PC register with the branch target. It also replaces the control fields of the instruction that is being latched into the fetch/decode register with zeros, which turns that instruction into a no-op. A taken branch therefore costs a single bubble.

Top module: `id_branch_resolver`

## Requirements
- R1: While `rst_n` is low, `fetch_pc` holds `RESET_PC` (0 by default) and `ifid_ctrl` is all zeros.
- R2: `br_target` always equals `id_pc_plus4 + (id_offset << 2)`, truncated to `AW` bits. A negative offset moves backwards and the sum wraps modulo 2^AW. For example, 44 with offset 7 gives 72.
- R3: With only `id_br_eq` high, `br_take` is 1 exactly when `id_rs_val` and `id_rt_val` are identical in every bit.
- R4: With only `id_br_ne` high, `br_take` is 1 exactly when the operands differ in at least one bit.
- R5: With both `id_br_eq` and `id_br_ne` low, `br_take` and `ifid_flush` stay 0 whatever the operand values are.
- R6: `ifid_flush` equals `br_take` in the same cycle.
- R7: On each rising edge out of reset, `fetch_pc` is loaded with `br_target` if `br_take` was 1 before the edge. Otherwise it is loaded with `fetch_pc + 4`.
- R8: On each rising edge out of reset, `ifid_ctrl` is loaded with all zeros if `ifid_flush` was 1 before the edge. Otherwise it is loaded with `if_ctrl`.
- R9: With both decode flags high, the branch is taken whatever the operand values are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| id_pc_plus4 | input | AW | Incremented PC of the instruction in decode |
| id_offset | input | AW | Sign-extended word offset of the branch |
| id_rs_val | input | DW | First compare operand |
| id_rt_val | input | DW | Second compare operand |
| id_br_eq | input | 1 | Decode flag: branch if equal |
| id_br_ne | input | 1 | Decode flag: branch if not equal |
| if_ctrl | input | CW | Control fields of the instruction being fetched |
| br_target | output | AW | Computed branch target |
| br_take | output | 1 | PC multiplexer select: redirect to target |
| ifid_flush | output | 1 | Strobe that zeroes the incoming fetch/decode control |
| fetch_pc | output | AW | Fetch PC register |
| ifid_ctrl | output | CW | Control fields held in the fetch/decode register |

## Verification
The bench targets operands that differ only in the top bit or only in the bottom bit, because a comparator that drops an end bit or pads the tree wrongly would report equality there. It drives negative offsets and a target sum that overflows the address width; a design that zero-extends the offset or scales it by the wrong amount would send fetch to the wrong address. Decode cycles with no branch flag but equal operands catch a design that lets the comparator leak into the flush. Taken branches carry non-zero fetched control, so a design that flushes one cycle late, or does not flush at all, lets a live instruction through where a bubble should be.

// File: rtl/br_res_pkg.sv
package br_res_pkg;

    typedef enum logic [1:0] {
        BK_NONE = 2'b00,
        BK_EQ   = 2'b01,
        BK_NE   = 2'b10,
        BK_ANY  = 2'b11
    } br_kind_e;

    function automatic br_kind_e kind_of(input logic eq_flag, input logic ne_flag);
        return br_kind_e'({ne_flag, eq_flag});
    endfunction

    function automatic logic resolve_take(input br_kind_e kind, input logic same);
        logic t;
        unique case (kind)
            BK_EQ:   t = same;
            BK_NE:   t = ~same;
            BK_ANY:  t = 1'b1;
            default: t = 1'b0;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/br_eq_compare.sv
module br_eq_compare #(
    parameter int DW          = 32,
    parameter bit REDUCE_TREE = 1'b1
) (
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    output logic          same
);
    localparam int LVL = (DW > 1) ? $clog2(DW) : 0;
    localparam int P   = 1 << LVL;

    logic [DW-1:0] diff;

    for (genvar i = 0; i < DW; i++) begin : g_xor
        assign diff[i] = op_a[i] ^ op_b[i];
    end

    if (REDUCE_TREE) begin : g_tree
        for (genvar l = 0; l <= LVL; l++) begin : g_lvl
            logic [(P >> l)-1:0] v;
            if (l == 0) begin : g_leaf
                for (genvar k = 0; k < P; k++) begin : g_pad
                    if (k < DW) begin : g_bit
                        assign v[k] = diff[k];
                    end else begin : g_zero
                        assign v[k] = 1'b0;
                    end
                end
            end else begin : g_node
                for (genvar k = 0; k < (P >> l); k++) begin : g_or
                    assign v[k] = g_lvl[l-1].v[2*k] | g_lvl[l-1].v[2*k+1];
                end
            end
        end
        assign same = ~g_lvl[LVL].v[0];
    end else begin : g_flat
        assign same = ~|diff;
    end

endmodule

// File: rtl/br_target_adder.sv
module br_target_adder #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] pc_plus4,
    input  logic [AW-1:0] word_off,
    output logic [AW-1:0] target
);
    logic [AW-1:0] byte_off;

    assign byte_off = {word_off[AW-3:0], 2'b00};
    assign target   = pc_plus4 + byte_off;

endmodule

// File: rtl/id_branch_resolver.sv
module id_branch_resolver
    import br_res_pkg::*;
#(
    parameter int          AW          = 32,
    parameter int          DW          = 32,
    parameter int          CW          = 8,
    parameter logic [31:0] RESET_PC    = 32'h0,
    parameter bit          REDUCE_TREE = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] id_pc_plus4,
    input  logic [AW-1:0] id_offset,
    input  logic [DW-1:0] id_rs_val,
    input  logic [DW-1:0] id_rt_val,
    input  logic          id_br_eq,
    input  logic          id_br_ne,
    input  logic [CW-1:0] if_ctrl,
    output logic [AW-1:0] br_target,
    output logic          br_take,
    output logic          ifid_flush,
    output logic [AW-1:0] fetch_pc,
    output logic [CW-1:0] ifid_ctrl
);
    localparam logic [AW-1:0] PC_STEP = AW'(4);
    localparam logic [AW-1:0] PC_INIT = AW'(RESET_PC);

    typedef struct packed {
        logic [AW-1:0] pc;
        logic [CW-1:0] ctrl;
    } fe_state_t;

    fe_state_t st_d, st_q;
    logic      ops_same;
    logic      take_d;
    br_kind_e  kind_d;

    br_eq_compare #(
        .DW          (DW),
        .REDUCE_TREE (REDUCE_TREE)
    ) u_cmp (
        .op_a (id_rs_val),
        .op_b (id_rt_val),
        .same (ops_same)
    );

    br_target_adder #(
        .AW (AW)
    ) u_tgt (
        .pc_plus4 (id_pc_plus4),
        .word_off (id_offset),
        .target   (br_target)
    );

    always_comb begin
        kind_d  = kind_of(id_br_eq, id_br_ne);
        take_d  = resolve_take(kind_d, ops_same);
        st_d    = st_q;
        st_d.pc = take_d ? br_target : (st_q.pc + PC_STEP);
        // flushed slot: every control field cleared so the slot acts as a no-op
        st_d.ctrl = take_d ? '0 : if_ctrl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pc   <= PC_INIT;
            st_q.ctrl <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign br_take    = take_d;
    assign ifid_flush = take_d;
    assign fetch_pc   = st_q.pc;
    assign ifid_ctrl  = st_q.ctrl;

endmodule

// File: rtl/br_resolver_chk.sv
module br_resolver_chk #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] id_rs_val,
    input logic [DW-1:0] id_rt_val,
    input logic          id_br_eq,
    input logic          id_br_ne,
    input logic          br_take,
    input logic          ifid_flush,
    input logic [AW-1:0] br_target,
    input logic [AW-1:0] fetch_pc,
    input logic [CW-1:0] ifid_ctrl
);
    logic live_q;

    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    AST_EQ_SAME_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (id_br_eq && !id_br_ne) |-> (br_take == (id_rs_val == id_rt_val))); // R3

    AST_NE_DIFF_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (id_br_ne && !id_br_eq) |-> (br_take == (id_rs_val != id_rt_val))); // R4

    AST_IDLE_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (!id_br_eq && !id_br_ne) |-> (!ifid_flush && !br_take)); // R5

    AST_SEQ_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !$past(br_take)) |-> (fetch_pc == AW'($past(fetch_pc) + AW'(4)))); // R7

    AST_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(br_take)) |-> (fetch_pc == $past(br_target))); // R7

    AST_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(ifid_flush)) |-> (ifid_ctrl == '0)); // R8

    AST_BOTH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (id_br_eq && id_br_ne) |-> br_take); // R9

endmodule

bind id_branch_resolver br_resolver_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (.*);

// File: tb/id_branch_resolver_tb_top.sv
module id_branch_resolver_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] id_pc_plus4 = '0;
    logic [AW-1:0] id_offset = '0;
    logic [DW-1:0] id_rs_val = '0;
    logic [DW-1:0] id_rt_val = '0;
    logic          id_br_eq = 1'b0;
    logic          id_br_ne = 1'b0;
    logic [CW-1:0] if_ctrl = '0;
    logic [AW-1:0] br_target;
    logic          br_take;
    logic          ifid_flush;
    logic [AW-1:0] fetch_pc;
    logic [CW-1:0] ifid_ctrl;

    int n_checks = 0;
    int n_errors = 0;

    typedef struct {
        string         tag;
        logic          take;
        logic [AW-1:0] tgt;
        logic [AW-1:0] pc;
        logic [CW-1:0] ctrl;
    } exp_t;

    exp_t          sb_q[$];
    logic [AW-1:0] model_pc;
    bit            drv_done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    id_branch_resolver dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .id_pc_plus4 (id_pc_plus4),
        .id_offset   (id_offset),
        .id_rs_val   (id_rs_val),
        .id_rt_val   (id_rt_val),
        .id_br_eq    (id_br_eq),
        .id_br_ne    (id_br_ne),
        .if_ctrl     (if_ctrl),
        .br_target   (br_target),
        .br_take     (br_take),
        .ifid_flush  (ifid_flush),
        .fetch_pc    (fetch_pc),
        .ifid_ctrl   (ifid_ctrl)
    );

    task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", what, act, exp);
        end
    endtask

    task automatic drive(input string tag, input bit eq, input bit ne,
                         input logic [DW-1:0] a, input logic [DW-1:0] b,
                         input logic [AW-1:0] pc4, input logic [AW-1:0] off,
                         input logic [CW-1:0] ctl);
        exp_t e;
        @(posedge clk);
        #(CLK_PERIOD/4);
        id_br_eq = eq; id_br_ne = ne; id_rs_val = a; id_rt_val = b;
        id_pc_plus4 = pc4; id_offset = off; if_ctrl = ctl;
        e.tag  = tag;
        e.take = (eq && ne) || (eq && (a == b)) || (ne && (a != b));
        e.tgt  = pc4 + (off << 2);
        e.pc   = e.take ? e.tgt : model_pc + 32'd4;
        e.ctrl = e.take ? '0 : ctl;
        model_pc = e.pc;
        sb_q.push_back(e);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                check({e.tag, " R3/R4/R5/R9 br_take"}, 64'(br_take), 64'(e.take));
                check({e.tag, " R6 ifid_flush"}, 64'(ifid_flush), 64'(e.take));
                check({e.tag, " R2 br_target"}, 64'(br_target), 64'(e.tgt));
                @(posedge clk);
                #1;
                check({e.tag, " R7 fetch_pc"}, 64'(fetch_pc), 64'(e.pc));
                check({e.tag, " R8 ifid_ctrl"}, 64'(ifid_ctrl), 64'(e.ctrl));
            end
        end
    end

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        n_errors++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin : stimulus
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset fetch_pc", 64'(fetch_pc), 64'h0);
        check("R1 reset ifid_ctrl", 64'(ifid_ctrl), 64'h0);
        rst_n = 1'b1;
        model_pc = 32'd4; // first edge out of reset advances sequentially

        // R3: equal operands, branch at 40, offset 7 -> 72, bubble (R8)
        drive("beq_taken_R3", 1, 0, 32'h1234, 32'h1234, 32'd44, 32'd7, 8'hA5);
        // R3: LSB differs -> not taken, sequential fetch (R7)
        drive("beq_lsb_R3", 1, 0, 32'h1235, 32'h1234, 32'd44, 32'd7, 8'h3C);
        // R4: only MSB differs -> taken
        drive("bne_msb_R4", 0, 1, 32'h8000_0000, 32'h0, 32'd200, 32'd3, 8'hFF);
        // R4: equal -> not taken
        drive("bne_same_R4", 0, 1, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'd300, 32'd1, 8'h11);
        // R5: no branch, equal operands
        drive("idle_same_R5", 0, 0, 32'h55, 32'h55, 32'd400, 32'd9, 8'h22);
        // R5: no branch, different operands
        drive("idle_diff_R5", 0, 0, 32'h1, 32'h2, 32'd404, 32'd9, 8'h33);
        // R2: negative offset 100 - 20 -> 80
        drive("neg_off_R2", 1, 0, 32'h0, 32'h0, 32'd100, 32'hFFFF_FFFB, 8'h44);
        // R2: target sum wraps past 2^32
        drive("wrap_R2", 0, 1, 32'h7, 32'h8, 32'hFFFF_FFF0, 32'd8, 8'h55);
        // R9: both flags, operands differ and equal
        drive("both_diff_R9", 1, 1, 32'h1, 32'h2, 32'd500, 32'd2, 8'h66);
        drive("both_same_R9", 1, 1, 32'h9, 32'h9, 32'd600, 32'hFFFF_FFFF, 8'h77);
        // back-to-back taken then not-taken: R7 and R8 across consecutive edges
        drive("b2b_taken_R8", 1, 0, 32'h0, 32'h0, 32'd1000, 32'd16, 8'h88);
        drive("b2b_seq_R7", 1, 0, 32'h0, 32'h1, 32'd1000, 32'd16, 8'h99);
        drive("tail_R5", 0, 0, 32'h0, 32'h0, 32'd0, 32'd0, 8'h00);

        drv_done = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule